// File: doc/BRIEF.md
# Multi-Mode Reed-Solomon Syndrome Calculator

This block computes the syndromes of a received Reed-Solomon word for the cable-TV code variants. A single bank of twenty Horner-rule cells serves all modes. A two-bit mode value is taken with the first symbol of each word. It picks the Galois field (GF(2^8) or GF(2^7)), the number of syndromes 2t, and the power of the first root. Cells that the mode does not need are not clocked. The six lowest cells can switch between the two fields.

Symbols enter one per cycle while `in_valid` is high, highest-degree coefficient first. `in_start` marks the first symbol and `in_last` marks the final one. In the cycle after the final symbol, the block raises `done_o` for one cycle. From that cycle on, the syndromes and an error flag are held until the next word completes. The error flag looks only at the first t syndromes. The key equation solver, Chien search and correction stages consume these results downstream.

Top module: `rs_syndrome_mm`

## Requirements
- R1: After reset, `done_o` and `err_o` are 0 and every lane of `syn_o` is 0.
- R2: Mode codes 2'b00 and 2'b11 use GF(2^8) with polynomial x^8+x^4+x^3+x^2+1 and alpha = 0x02. Lane i (i = 0..15) of `syn_o` (bits 8i+7:8i) holds r(alpha^i), where the received word is r(x) = sum of r_j x^(n-1-j) and r_0 is the first symbol.
- R3: Mode code 2'b01 uses GF(2^8) and gives 20 syndromes. Lane i (i = 0..19) holds r(alpha^i).
- R4: Mode code 2'b10 uses GF(2^7) with polynomial x^7+x^3+1 and alpha = 0x02. Lane i (i = 0..5) holds r(alpha^(i+1)). Bit 7 of every input symbol is ignored, and bit 7 of every lane reads 0.
- R5: Lanes at or above the mode's syndrome count (16, 20 or 6) read 0 when a word completes.
- R6: A symbol with `in_start` restarts the computation and discards any unfinished word. A word made of one symbol (start and last together) gives every active lane equal to that symbol, masked as in R4.
- R7: Cycles with `in_valid` low have no effect, whatever the values of the other inputs.
- R8: `done_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the symbol carrying `in_last`. `syn_o` and `err_o` take their new values in that same cycle and hold them until the next completion.
- R9: `err_o` is 1 exactly when at least one of the first t lanes is nonzero (t = 8, 10, 3 for modes 00/11, 01, 10). A word that is a multiple of the generator polynomial gives `err_o` = 0 and all lanes 0.
- R10: The mode is sampled with the start symbol. Changes of `in_mode` on later symbols of the same word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Symbol qualifier |
| in_start | input | 1 | First symbol of a word |
| in_last | input | 1 | Final symbol of a word |
| in_mode | input | 2 | Code variant, sampled with the start symbol |
| in_sym | input | 8 | Received symbol |
| syn_o | output | 160 | Syndrome lanes, lane i at bits 8i+7:8i |
| err_o | output | 1 | Nonzero syndrome among the first t lanes |
| done_o | output | 1 | One-cycle pulse when the results are updated |

## Verification
All three results (`done_o`, `syn_o` and `err_o`) are due one clock edge after the edge that accepts the final symbol. The bench drives inputs on falling edges. It therefore compares all three at the very next falling edge after that final symbol is driven, never later. One cycle further on, it checks that `done_o` has dropped while the syndromes and flag still hold. Back-to-back words are sent with no idle cycle. This confirms that the results arrive in time even when the next start symbol is already being accepted.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
  localparam int SYM_W    = 8;
  localparam int NUM_SYN  = 20;
  localparam int NUM_DUAL = 6;
  localparam logic [8:0] POLY_WIDE   = 9'h11D;
  localparam logic [8:0] POLY_NARROW = 9'h089;

  typedef enum logic [1:0] {
    MODE_AC  = 2'd0,
    MODE_D   = 2'd1,
    MODE_B   = 2'd2,
    MODE_AC2 = 2'd3
  } rs_mode_e;

  // Shift-and-add product, reduced by poly after every shift.
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [8:0] poly, input int m);
    logic [8:0] sh;
    logic [7:0] p;
    p  = '0;
    sh = {1'b0, a};
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ sh[7:0];
      sh = sh << 1;
      if (sh[m]) sh = sh ^ poly;
    end
    return p;
  endfunction

  function automatic logic [7:0] alpha_pow(input int e, input logic [8:0] poly, input int m);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 0; k < e; k++) r = gf_mul(r, 8'h02, poly, m);
    return r;
  endfunction

  function automatic int syn_count(input rs_mode_e md);
    case (md)
      MODE_D:  return 20;
      MODE_B:  return 6;
      default: return 16;
    endcase
  endfunction

  function automatic logic [NUM_SYN-1:0] lane_mask(input int cnt);
    logic [NUM_SYN-1:0] mk;
    for (int i = 0; i < NUM_SYN; i++) mk[i] = (i < cnt);
    return mk;
  endfunction
endpackage

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_syn_pkg::*;
#(
  parameter int IDX  = 0,
  parameter bit DUAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic             narrow,
  input  logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] s_q,
  output logic [SYM_W-1:0] s_nxt
);
  localparam logic [7:0] K_WIDE = alpha_pow(IDX, POLY_WIDE, 8);

  logic [SYM_W-1:0] prod_wide;
  logic [SYM_W-1:0] prod_narrow;

  always_comb prod_wide = gf_mul(s_q, K_WIDE, POLY_WIDE, 8);

  generate
    if (DUAL) begin : g_dual
      localparam logic [7:0] K_NARROW = alpha_pow(IDX + 1, POLY_NARROW, 7);
      always_comb prod_narrow = gf_mul(s_q, K_NARROW, POLY_NARROW, 7);
    end else begin : g_wide
      always_comb prod_narrow = '0;
    end
  endgenerate

  // Horner step: S <= S * root + R, or R alone on a start symbol
  always_comb begin
    if (load) s_nxt = sym;
    else if (narrow) s_nxt = prod_narrow ^ sym;
    else s_nxt = prod_wide ^ sym;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else if (en) s_q <= s_nxt;
  end

  // R4
  narrow_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && narrow) |=> (s_q[SYM_W-1] == 1'b0));
endmodule

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl
  import rs_syn_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n_a,
  input  logic               in_valid,
  input  logic               in_start,
  input  logic               in_last,
  input  logic [1:0]         in_mode,
  output logic               rst_n_s,
  output logic               load,
  output logic               narrow,
  output logic               capture,
  output logic [NUM_SYN-1:0] lane_en,
  output logic [NUM_SYN-1:0] chk_en,
  output rs_mode_e           mode_q,
  output logic               done_q
);
  logic [1:0] rst_pipe;
  rs_mode_e   cur_mode;
  rs_mode_e   mode_d;
  logic       done_d;
  int         cnt;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) rst_pipe <= '0;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_comb begin
    load     = in_valid && in_start;
    capture  = in_valid && in_last;
    cur_mode = load ? rs_mode_e'(in_mode) : mode_q;
    narrow   = (cur_mode == MODE_B);
    cnt      = syn_count(cur_mode);
    lane_en  = lane_mask(cnt) & {NUM_SYN{in_valid}};
    chk_en   = lane_mask(cnt / 2);
    mode_d   = cur_mode;
    done_d   = capture;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= MODE_AC;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/rs_syndrome_mm.sv
module rs_syndrome_mm
  import rs_syn_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_start,
  input  logic                     in_last,
  input  logic [1:0]               in_mode,
  input  logic [7:0]               in_sym,
  output logic [NUM_SYN*SYM_W-1:0] syn_o,
  output logic                     err_o,
  output logic                     done_o
);
  logic               rst_n_s, load, narrow, capture;
  logic [NUM_SYN-1:0] lane_en, chk_en;
  rs_mode_e           mode_q;
  logic [SYM_W-1:0]   sym_m;
  logic [NUM_SYN-1:0][SYM_W-1:0] s_q, s_nxt, syn_q, syn_d;
  logic [NUM_SYN-1:0] nz_nxt;
  logic               err_q, err_d;

  rs_syn_ctrl u_ctrl (
    .clk(clk), .rst_n_a(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_mode(in_mode), .rst_n_s(rst_n_s), .load(load),
    .narrow(narrow), .capture(capture), .lane_en(lane_en), .chk_en(chk_en),
    .mode_q(mode_q), .done_q(done_o)
  );

  assign sym_m = narrow ? {1'b0, in_sym[SYM_W-2:0]} : in_sym;

  generate
    for (genvar i = 0; i < NUM_SYN; i++) begin : g_cell
      rs_syn_cell #(.IDX(i), .DUAL(i < NUM_DUAL)) u_cell (
        .clk(clk), .rst_n(rst_n_s), .en(lane_en[i]), .load(load),
        .narrow(narrow), .sym(sym_m), .s_q(s_q[i]), .s_nxt(s_nxt[i])
      );
      assign nz_nxt[i] = |s_nxt[i];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NUM_SYN; i++)
      syn_d[i] = capture ? (lane_en[i] ? s_nxt[i] : '0) : syn_q[i];
    err_d = capture ? |(nz_nxt & chk_en) : err_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      syn_q <= '0;
      err_q <= 1'b0;
    end else begin
      syn_q <= syn_d;
      err_q <= err_d;
    end
  end

  assign syn_o = syn_q;
  assign err_o = err_q;

  // Lane views of the finished word, for the checks below
  logic [NUM_SYN-1:0] out_nz, out_msb, done_lanes, done_chk;
  always_comb begin
    for (int i = 0; i < NUM_SYN; i++) begin
      out_nz[i]  = |syn_q[i];
      out_msb[i] = syn_q[i][SYM_W-1];
    end
    done_lanes = lane_mask(syn_count(mode_q));
    done_chk   = lane_mask(syn_count(mode_q) / 2);
  end

  // R5
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> ((out_nz & ~done_lanes) == '0));
  // R9
  err_first_t_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> (err_o == |(out_nz & done_chk)));
  // R4
  narrow_out_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && mode_q == MODE_B) |-> (out_msb == '0));
endmodule

// File: tb/rs_syndrome_mm_tb.sv
module rs_syndrome_mm_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_start, in_last;
  logic [1:0]   in_mode;
  logic [7:0]   in_sym;
  logic [159:0] syn_o;
  logic         err_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] w [0:255];
  int         wn;
  logic [7:0] exp_s [0:19];
  logic       exp_err;

  always #4 clk = ~clk;

  rs_syndrome_mm u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_mode(in_mode), .in_sym(in_sym),
    .syn_o(syn_o), .err_o(err_o), .done_o(done_o)
  );

  function automatic bit is_nar(input int md); return md == 2; endfunction
  function automatic int nsyn(input int md);
    return (md == 1) ? 20 : (md == 2) ? 6 : 16;
  endfunction
  function automatic int fcr(input int md); return (md == 2) ? 1 : 0; endfunction

  // Full carry-less product, then reduction from the top bit down
  function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b, input bit nar);
    logic [14:0] p;
    logic [14:0] pl;
    int m;
    m  = nar ? 7 : 8;
    pl = nar ? 15'h089 : 15'h11D;
    p  = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ ({7'd0, a} << i);
    for (int k = 14; k >= 7; k--) if (k >= m && p[k]) p = p ^ (pl << (k - m));
    return p[7:0];
  endfunction

  function automatic logic [7:0] tpow(input int e, input bit nar);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 0; k < e; k++) r = tmul(r, 8'h02, nar);
    return r;
  endfunction

  task automatic compute_expected(input int md);
    logic [7:0] beta, acc, x, s;
    bit nar;
    nar = is_nar(md);
    exp_err = 1'b0;
    for (int i = 0; i < 20; i++) begin
      exp_s[i] = 8'h00;
      if (i < nsyn(md)) begin
        beta = tpow(fcr(md) + i, nar);
        acc = 8'h00;
        x = 8'h01;
        for (int j = wn - 1; j >= 0; j--) begin
          s = nar ? (w[j] & 8'h7F) : w[j];
          acc = acc ^ tmul(s, x, nar);
          x = tmul(x, beta, nar);
        end
        exp_s[i] = acc;
        if (i < nsyn(md) / 2 && acc != 8'h00) exp_err = 1'b1;
      end
    end
  endtask

  task automatic check_lanes(input string tag);
    int bad;
    bad = -1;
    n_tests++;
    for (int i = 19; i >= 0; i--) if (syn_o[8*i +: 8] !== exp_s[i]) bad = i;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s syndrome lane %0d: actual %h expected %h", tag, bad,
               syn_o[8*bad +: 8], exp_s[bad]);
    end
    n_tests++;
    if (err_o !== exp_err) begin
      n_fail++;
      $display("FAIL %s err_o: actual %b expected %b", tag, err_o, exp_err);
    end
  endtask

  task automatic check_done(input string tag);
    n_tests++;
    if (done_o !== 1'b1) begin
      n_fail++;
      $display("FAIL %s done_o: actual %b expected 1", tag, done_o);
    end
    check_lanes(tag);
  endtask

  // Called on a falling edge; ends on the falling edge where results are due
  task automatic send_word(input int md, input bit gaps, input bit chg, input string tag);
    for (int j = 0; j < wn; j++) begin
      if (gaps && $urandom_range(0, 2) == 0) begin
        in_valid = 1'b0;
        in_start = ($urandom_range(0, 1) == 1);
        in_last  = ($urandom_range(0, 1) == 1);
        in_sym   = 8'($urandom);
        in_mode  = 2'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_start = (j == 0);
      in_last  = (j == wn - 1);
      in_sym   = w[j];
      in_mode  = (j == 0 || !chg) ? 2'(md) : 2'($urandom);
      @(negedge clk);
    end
    compute_expected(md);
    check_done(tag);
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    in_start = 1'b1;
    in_last  = 1'b1;
    in_sym   = 8'hA5;
    @(negedge clk);
    n_tests++;
    if (done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 done_o not a single pulse: actual %b expected 0", done_o);
    end
    check_lanes("R8 hold/R7 idle");
  endtask

  task automatic fill_random(input int md, input int len);
    wn = len;
    for (int j = 0; j < len; j++) w[j] = 8'($urandom);
    if (is_nar(md)) for (int j = 0; j < len; j++) w[j][7] = ($urandom_range(0, 1) == 1);
  endtask

  // Codeword = message * generator, generator roots alpha^(fcr+k), k < 2t
  task automatic fill_codeword(input int md, input int msg_len);
    logic [7:0] g [0:20];
    logic [7:0] msg [0:31];
    logic [7:0] c [0:63];
    logic [7:0] beta;
    int deg, n;
    bit nar;
    nar = is_nar(md);
    deg = nsyn(md);
    for (int d = 0; d <= 20; d++) g[d] = 8'h00;
    g[0] = 8'h01;
    for (int k = 0; k < deg; k++) begin
      beta = tpow(fcr(md) + k, nar);
      for (int d = k + 1; d >= 1; d--) g[d] = g[d-1] ^ tmul(g[d], beta, nar);
      g[0] = tmul(g[0], beta, nar);
    end
    for (int a = 0; a < msg_len; a++) msg[a] = nar ? (8'($urandom) & 8'h7F) : 8'($urandom);
    n = msg_len + deg;
    for (int d = 0; d < n; d++) c[d] = 8'h00;
    for (int a = 0; a < msg_len; a++)
      for (int d = 0; d <= deg; d++) c[a+d] = c[a+d] ^ tmul(msg[a], g[d], nar);
    wn = n;
    for (int j = 0; j < n; j++) w[j] = c[n-1-j];
  endtask

  function automatic string tag_of(input int md);
    return (md == 1) ? "R3" : (md == 2) ? "R4" : "R2";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_mode = 2'd0; in_sym = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 20; i++) exp_s[i] = 8'h00;
    exp_err = 1'b0;
    n_tests++;
    if (done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 done_o: actual %b expected 0", done_o);
    end
    check_lanes("R1");

    // R6: exhaustive one-symbol words, back to back, every mode code
    for (int md = 0; md < 4; md++) begin
      for (int v = 0; v < 256; v++) begin
        wn = 1;
        w[0] = 8'(v);
        send_word(md, 1'b0, 1'b0, {"R6/", tag_of(md)});
      end
      idle_check();
    end

    // R7 gaps and R10 mode changes inside random words
    for (int md = 0; md < 4; md++) begin
      for (int r = 0; r < 6; r++) begin
        fill_random(md, $urandom_range(2, 48));
        send_word(md, (r % 2) == 1, r >= 3, {"R7/R10/", tag_of(md)});
        idle_check();
      end
    end

    // R9: codewords give no error; a single injected error is flagged
    for (int md = 0; md < 4; md++) begin
      for (int r = 0; r < 3; r++) begin
        fill_codeword(md, $urandom_range(1, 24));
        send_word(md, 1'b0, 1'b0, "R9 codeword");
        n_tests++;
        if (exp_err !== 1'b0) begin
          n_fail++;
          $display("FAIL R9 bench codeword: actual err %b expected 0", exp_err);
        end
        begin
          int p;
          p = $urandom_range(0, wn - 1);
          w[p] = w[p] ^ (is_nar(md) ? 8'(($urandom % 127) + 1) : 8'(($urandom % 255) + 1));
        end
        send_word(md, 1'b1, 1'b0, "R9 single error");
        idle_check();
      end
    end

    // R6: a new start abandons an unfinished word
    for (int md = 0; md < 4; md++) begin
      for (int j = 0; j < 3; j++) begin
        in_valid = 1'b1; in_start = (j == 0); in_last = 1'b0;
        in_sym = 8'($urandom); in_mode = 2'((md + 1) % 4);
        @(negedge clk);
      end
      fill_random(md, 10);
      send_word(md, 1'b0, 1'b0, "R6 restart");
      idle_check();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule